// File: doc/BRIEF.md
# SPI port with request handshake

This block is a serial peripheral port that works either as bus master or as bus slave. A configuration input picks the role. Words are 24 bits long and move MSB first in clock mode 0. Data is sampled on the rising SCK edge and changed on the falling edge. The host loads a transmit word through a parallel input. It reads the received word, together with a one-cycle completion pulse, on a parallel output.

Each word is paced by an active-low request line, and the direction of that line follows the role.

- **Slave role:** the port pulls the line low once the host has loaded the next transmit word. It lets the line go high at the first SCK rise of that word.
- **Master role:** the line is an input from the far slave. Every new falling edge on it starts exactly one word. SCK comes from the system clock through a programmable half-period divider.

The serial inputs (SCK, select, MOSI and request) pass through two-flop synchronizers before any edge is detected. Every bidirectional pin comes as an input, an output and an output enable.

In the master role the select input must stay high. If it is seen low, a sticky bus-error flag is set. In the slave role a high select makes the port ignore SCK and float MISO.

Top module: `spi_req_port`

## Requirements
- R1: In the master role no word starts while the synchronized request input stays high (deasserted); SCK stays low and no completion pulse appears.
- R2: In the master role each high-to-low transition of the request input starts exactly one word; holding the input low after a word starts no further word.
- R3: In the master role a word shifts 24 bits MSB first out of `mosi_o`, samples `miso_i` on each SCK rise, and the completed word equals the bits received in order, first bit in bit 23.
- R4: In the master role SCK has a high phase and a low phase of `cfg_half` system clocks each (0 acts as 1), and it idles low once the word is complete.
- R5: In the slave role, with select low, the port captures `mosi_i` on SCK rises into `rx_word`, MSB first. It presents the loaded transmit word on `miso_o`, MSB first, and advances it on SCK falls.
- R6: In the slave role, while select is high, SCK edges start no word and `miso_oe` is 0.
- R7: In the slave role, loading a transmit word drives the request pin low (`hreq_n_o` = 0). The first SCK rise of the following word releases it (`hreq_n_o` = 1).
- R8: `hreq_n_oe` is 0 during reset, in the master role, and whenever `cfg_req_en` is 0.
- R9: In the master role a low select input sets `bus_err`. The flag stays set until `err_clr` is pulsed, and a set in the same cycle as a clear wins. The slave role never sets it.
- R10: Each completed word raises `rx_done` for exactly one system clock, and `rx_word` holds the new word in that cycle.
- R11: After reset `rx_done`, `bus_err`, `sck_o` and `miso_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 selects the master role, 0 the slave role |
| cfg_req_en | input | 1 | Request-pin output enable control |
| cfg_half | input | DIV_W | SCK half period in system clocks (master role) |
| tx_load | input | 1 | Load `tx_word` into the shifter when no word is in progress |
| tx_word | input | WORD_W | Parallel transmit word |
| rx_word | output | WORD_W | Last received word |
| rx_done | output | 1 | One-cycle pulse when a word completes |
| bus_err | output | 1 | Sticky bus-error flag |
| err_clr | input | 1 | Clears `bus_err` |
| sck_i | input | 1 | SCK pin input (slave role) |
| sck_o | output | 1 | SCK pin output (master role) |
| sck_oe | output | 1 | SCK output enable |
| ss_n_i | input | 1 | Select pin, active low |
| mosi_i | input | 1 | MOSI pin input (slave role) |
| mosi_o | output | 1 | MOSI pin output (master role) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input (master role) |
| miso_o | output | 1 | MISO pin output (slave role) |
| miso_oe | output | 1 | MISO output enable |
| hreq_n_i | input | 1 | Request pin input, active low (master role) |
| hreq_n_o | output | 1 | Request pin output, active low (slave role) |
| hreq_n_oe | output | 1 | Request pin output enable |

## Verification
Two events can land in the same cycle: the bus-error flag can be set by a low select while the host pulses `err_clr` to clear it. The bench holds select low in the master role and pulses the clear while the condition persists. It expects the flag to remain 1 afterwards, and it expects the flag to clear only once select is high again. A second overlap is the request input falling again while a master word is still running. The bench holds the line low across a whole word and judges that no extra word follows until a fresh falling edge arrives.

// File: rtl/spi_req_port.sv
module spi_req_port #(
  parameter int WORD_W = 24,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_req_en,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_done,
  output logic              bus_err,
  input  logic              err_clr,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              hreq_n_i,
  output logic              hreq_n_o,
  output logic              hreq_n_oe
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [1:0] sck_sy, ss_sy, mosi_sy, req_sy;
  logic sck_d, req_d;
  logic [WORD_W-1:0] sh, rx_q;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] dcnt;
  logic rbit, done_q, err_q, rdy, pend, m_run, sck_q;

  wire ss_act  = ~ss_sy[1];
  wire s_rise  = sck_sy[1] & ~sck_d & ss_act;
  wire s_fall  = ~sck_sy[1] & sck_d & ss_act;
  wire req_fall = req_d & ~req_sy[1];

  wire [DIV_W-1:0] half_m1 = (cfg_half == '0) ? '0 : cfg_half - 1'b1;
  wire tick   = m_run && (dcnt == half_m1);
  wire m_rise = tick & ~sck_q;
  wire m_fall = tick & sck_q;

  wire rise   = cfg_master ? m_rise : s_rise;
  wire fall   = cfg_master ? m_fall : s_fall;
  wire in_bit = cfg_master ? miso_i : mosi_sy[1];
  wire last   = rise && (cnt == CNT_W'(WORD_W - 1));
  wire idle   = (cnt == '0) && !m_run;
  wire start  = cfg_master && idle && pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= 2'b00;
      ss_sy   <= 2'b11;
      mosi_sy <= 2'b00;
      req_sy  <= 2'b11;
      sck_d   <= 1'b0;
      req_d   <= 1'b1;
    end else begin
      sck_sy  <= {sck_sy[0], sck_i};
      ss_sy   <= {ss_sy[0], ss_n_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      req_sy  <= {req_sy[0], hreq_n_i};
      sck_d   <= sck_sy[1];
      req_d   <= req_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      rx_q   <= '0;
      cnt    <= '0;
      rbit   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (!cfg_master && !ss_act) begin
        cnt <= '0;
      end else if (rise) begin
        if (last) begin
          cnt  <= '0;
          rx_q <= {sh[WORD_W-2:0], in_bit};
        end else begin
          cnt  <= cnt + 1'b1;
          rbit <= in_bit;
        end
      end
      if (fall && cnt != '0)
        sh <= {sh[WORD_W-2:0], rbit};
      else if (tx_load && idle)
        sh <= tx_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 1'b0;
      dcnt  <= '0;
      sck_q <= 1'b0;
      pend  <= 1'b0;
    end else if (!cfg_master) begin
      m_run <= 1'b0;
      dcnt  <= '0;
      sck_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (req_fall) pend <= 1'b1;
      else if (start) pend <= 1'b0;
      if (start) begin
        m_run <= 1'b1;
        dcnt  <= '0;
        sck_q <= 1'b0;
      end else if (m_run) begin
        if (tick) begin
          dcnt  <= '0;
          sck_q <= ~sck_q;
          if (m_fall && cnt == '0) m_run <= 1'b0;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy   <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (cfg_master) rdy <= 1'b0;
      else if (tx_load && idle) rdy <= 1'b1;
      else if (rise && cnt == '0) rdy <= 1'b0;
      if (cfg_master && ss_act) err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign rx_word   = rx_q;
  assign rx_done   = done_q;
  assign bus_err   = err_q;
  assign sck_o     = sck_q;
  assign sck_oe    = cfg_master & rst_n;
  assign mosi_o    = sh[WORD_W-1];
  assign mosi_oe   = cfg_master & rst_n;
  assign miso_o    = sh[WORD_W-1];
  assign miso_oe   = ~cfg_master & ss_act;
  assign hreq_n_o  = ~rdy;
  assign hreq_n_oe = rst_n & cfg_req_en & ~cfg_master;
endmodule

module spi_req_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic cfg_req_en,
  input logic ss_n_i,
  input logic err_clr,
  input logic rx_done,
  input logic bus_err,
  input logic miso_oe,
  input logic hreq_n_oe
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !err_clr) |=> bus_err);

  // R9
  err_master_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> $past(cfg_master));

  // R8
  req_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_n_oe |-> (cfg_req_en && !cfg_master));

  // R6
  miso_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && $past(ss_n_i) && $past(ss_n_i, 2)) |-> !miso_oe);
endmodule

bind spi_req_port spi_req_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_req_en(cfg_req_en),
  .ss_n_i(ss_n_i), .err_clr(err_clr), .rx_done(rx_done), .bus_err(bus_err),
  .miso_oe(miso_oe), .hreq_n_oe(hreq_n_oe)
);

// File: tb/spi_req_port_bench.sv
module spi_req_port_bench;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b0, cfg_req_en = 1'b1;
  logic [7:0] cfg_half = 8'd3;
  logic tx_load = 1'b0, err_clr = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0, hreq_n_i = 1'b1;
  wire  [W-1:0] rx_word;
  wire rx_done, bus_err, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  wire hreq_n_o, hreq_n_oe, miso_i;

  assign miso_i = mosi_o;

  always #10 clk = ~clk;

  spi_req_port #(.WORD_W(W), .DIV_W(8)) u_spi_req_port (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_req_en(cfg_req_en),
    .cfg_half(cfg_half), .tx_load(tx_load), .tx_word(tx_word), .rx_word(rx_word),
    .rx_done(rx_done), .bus_err(bus_err), .err_clr(err_clr),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ss_n_i(ss_n_i),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .hreq_n_i(hreq_n_i), .hreq_n_o(hreq_n_o), .hreq_n_oe(hreq_n_oe)
  );

  int n_chk = 0, n_bad = 0, done_cnt = 0, wide_cnt = 0, hi_cnt = 0;
  logic [W-1:0] last_rx = '0;
  logic prev_done = 1'b0;
  bit finished = 0;

  always @(negedge clk) begin
    if (rx_done) begin
      done_cnt++;
      last_rx = rx_word;
    end
    if (rx_done && prev_done) wide_cnt++;
    prev_done = rx_done;
    if (sck_o && cfg_master) hi_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [W-1:0] v);
    tx_word = v;
    tx_load = 1'b1;
    wait_clk(1);
    tx_load = 1'b0;
  endtask

  task automatic slave_word(input logic [W-1:0] tx, input logic [W-1:0] snd);
    logic [W-1:0] got;
    int d0;
    got = '0;
    load(tx);
    check("R7 request low after load", {30'd0, hreq_n_oe, hreq_n_o}, 32'd2);
    ss_n_i = 1'b0;
    wait_clk(4);
    d0 = done_cnt;
    for (int i = W - 1; i >= 0; i--) begin
      mosi_i = snd[i];
      sck_i  = 1'b0;
      wait_clk(4);
      got[i] = miso_o;
      sck_i  = 1'b1;
      wait_clk(4);
      if (i == W - 1) check("R7 request released at first rise", {31'd0, hreq_n_o}, 32'd1);
    end
    sck_i = 1'b0;
    wait_clk(4);
    ss_n_i = 1'b1;
    wait_clk(4);
    check("R5 miso stream", {8'd0, got}, {8'd0, tx});
    check("R5 received word", {8'd0, last_rx}, {8'd0, snd});
    check("R10 one done per word", done_cnt - d0, 32'd1);
  endtask

  task automatic wait_done(input int d0);
    for (int t = 0; t < 4000 && done_cnt == d0; t++) wait_clk(1);
  endtask

  localparam logic [2*W-1:0] VEC [4] = '{
    {24'hA5C33C, 24'h123456},
    {24'hFFFFFF, 24'h000000},
    {24'h000001, 24'h800000},
    {24'h5A5A5A, 24'hC0FFEE}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected completion");
    report();
  end

  initial begin
    int d0;
    wait_clk(2);
    check("R8 request enable off in reset", {31'd0, hreq_n_oe}, 32'd0);
    wait_clk(1);
    rst_n = 1'b1;
    wait_clk(3);
    check("R11 reset outputs", {28'd0, rx_done, bus_err, sck_o, miso_oe}, 32'd0);

    // R5 R7 R10 table walk in slave role
    for (int v = 0; v < 4; v++) slave_word(VEC[v][2*W-1:W], VEC[v][W-1:0]);
    check("R9 no error in slave role", {31'd0, bus_err}, 32'd0);

    // R6 select high: SCK ignored
    load(24'h3C3C3C);
    d0 = done_cnt;
    for (int i = 0; i < 30; i++) begin
      sck_i = ~sck_i;
      wait_clk(4);
    end
    sck_i = 1'b0;
    wait_clk(4);
    check("R6 no word with select high", done_cnt - d0, 32'd0);
    check("R6 miso floats", {31'd0, miso_oe}, 32'd0);
    check("R6 request untouched", {31'd0, hreq_n_o}, 32'd0);

    // R8 enable control
    cfg_req_en = 1'b0;
    wait_clk(1);
    check("R8 request enable off", {31'd0, hreq_n_oe}, 32'd0);
    cfg_req_en = 1'b1;

    // Master role
    cfg_master = 1'b1;
    cfg_half = 8'd3;
    wait_clk(2);
    check("R8 request enable off in master", {31'd0, hreq_n_oe}, 32'd0);
    load(24'hC35A96);
    d0 = done_cnt;
    wait_clk(40);
    check("R1 no start without request", done_cnt - d0, 32'd0);
    check("R1 sck idle", {31'd0, sck_o}, 32'd0);
    hi_cnt = 0;
    hreq_n_i = 1'b0;
    wait_done(d0);
    check("R3 master word", {8'd0, last_rx}, {8'd0, 24'hC35A96});
    check("R10 master done count", done_cnt - d0, 32'd1);
    wait_clk(10);
    check("R4 sck high time", hi_cnt, 32'd72);
    check("R4 sck idles low", {31'd0, sck_o}, 32'd0);
    d0 = done_cnt;
    wait_clk(300);
    check("R2 held request starts nothing", done_cnt - d0, 32'd0);

    cfg_half = 8'd2;
    hreq_n_i = 1'b1;
    wait_clk(5);
    load(24'h0F1E2D);
    hi_cnt = 0;
    hreq_n_i = 1'b0;
    wait_done(d0);
    check("R2 fresh request starts one word", done_cnt - d0, 32'd1);
    check("R3 second master word", {8'd0, last_rx}, {8'd0, 24'h0F1E2D});
    wait_clk(10);
    check("R4 sck high time half 2", hi_cnt, 32'd48);
    hreq_n_i = 1'b1;

    // R9 bus error
    ss_n_i = 1'b0;
    wait_clk(5);
    check("R9 error set", {31'd0, bus_err}, 32'd1);
    err_clr = 1'b1;
    wait_clk(1);
    err_clr = 1'b0;
    wait_clk(1);
    check("R9 set wins over clear", {31'd0, bus_err}, 32'd1);
    ss_n_i = 1'b1;
    wait_clk(5);
    check("R9 error sticky", {31'd0, bus_err}, 32'd1);
    err_clr = 1'b1;
    wait_clk(1);
    err_clr = 1'b0;
    wait_clk(1);
    check("R9 error cleared", {31'd0, bus_err}, 32'd0);

    check("R10 done pulses single cycle", wide_cnt, 32'd0);
    report();
  end
endmodule